// File: doc/BRIEF.md
# Iterative Integer Divider

This block computes quotients and remainders for the integer divide group of a 64-bit processor. It covers signed and unsigned division, signed and unsigned remainder, and the 32-bit word variants of all four. A request carries two operands and three flags: quotient or remainder, signed or unsigned, and full width or word. The request is taken with a valid/ready handshake. The result appears as a 64-bit value together with a one-cycle valid pulse.

Ordinary requests run through a restoring shift-subtract loop on operand magnitudes. The loop retires one quotient bit per cycle, and the signs are fixed up at the end. Two requests finish in one cycle without looping: a zero divisor, and a signed division of the most negative value by -1. Word requests use the low half of each operand and return the half-width result sign-extended to full width. Instruction decode, the legality check that depends on what the core supports, and register access all sit with the surrounding pipeline.

Top module: `rv_divider`

## Requirements
- R1: A signed quotient (req_rem=0, req_unsigned=0) is rounded toward zero. A signed remainder (req_rem=1) has the sign of the dividend and satisfies dividend = quotient*divisor + remainder.
- R2: With req_unsigned=1 both operands are read as unsigned, and the result is the unsigned quotient or remainder.
- R3: When the divisor is zero, the quotient result is all ones for both signed and unsigned forms.
- R4: When the divisor is zero, the remainder result equals the dividend. For word forms this is the low half of the dividend, sign-extended.
- R5: A signed division of the most negative value by -1 returns the most negative value as its quotient and zero as its remainder. For word forms the most negative value is taken at half width and then sign-extended.
- R6: With req_word=1, only bits [XLEN/2-1:0] of each operand are used, read as signed or unsigned according to req_unsigned. The half-width result is sign-extended to XLEN bits.
- R7: A zero-divisor or overflow request raises rsp_valid at the clock edge that accepts it, and req_ready stays high.
- R8: Any other request drops req_ready for the whole computation. It raises rsp_valid XLEN+1 clock edges after the accepting edge for full-width forms, and XLEN/2+1 edges after it for word forms.
- R9: Each accepted request produces exactly one rsp_valid cycle. rsp_valid is only ever high while req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_a | input | XLEN | Dividend |
| req_b | input | XLEN | Divisor |
| req_rem | input | 1 | 1 = return remainder, 0 = return quotient |
| req_unsigned | input | 1 | 1 = unsigned operands, 0 = signed |
| req_word | input | 1 | 1 = half-width word form |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | XLEN | Result |

## Verification
The bench builds the divider at 8 bits, so each word form works on 4-bit values. It runs all eight forms across 128 dividends, which include the most negative values at both widths, against a set of divisors: zero, ±1, small odd and even values, and words whose low nibble and high byte differ in sign. Dividends of mixed signs separate true round-toward-zero from floor division, and they expose a remainder whose sign is wrong. Divisors that are zero only in the low nibble separate the word-form rules from the full-width ones. For each request the bench also measures the response latency and checks that the strobe lasts one cycle, which tells the one-cycle special paths apart from the iterating path.

// File: rtl/rv_divider.sv
module rv_divider #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [XLEN-1:0] req_a,
  input  logic [XLEN-1:0] req_b,
  input  logic            req_rem,
  input  logic            req_unsigned,
  input  logic            req_word,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_data
);
  localparam int WLEN = XLEN / 2;
  localparam int CW   = $clog2(XLEN + 1);
  localparam logic [XLEN-1:0] MIN_FULL = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] MIN_WORD = {{(WLEN+1){1'b1}}, {(WLEN-1){1'b0}}};

  function automatic logic [XLEN-1:0] fix(input logic [XLEN-1:0] x, input logic w);
    fix = w ? {{WLEN{x[WLEN-1]}}, x[WLEN-1:0]} : x;
  endfunction

  logic            busy;
  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] quo, rem, dvs;
  logic            neg_q, neg_r, sel_rem, wrd;

  wire [XLEN-1:0] wa = req_word ? {{WLEN{~req_unsigned & req_a[WLEN-1]}}, req_a[WLEN-1:0]} : req_a;
  wire [XLEN-1:0] wb = req_word ? {{WLEN{~req_unsigned & req_b[WLEN-1]}}, req_b[WLEN-1:0]} : req_b;
  wire a_neg = ~req_unsigned & wa[XLEN-1];
  wire b_neg = ~req_unsigned & wb[XLEN-1];
  wire [XLEN-1:0] a_mag = a_neg ? -wa : wa;
  wire [XLEN-1:0] b_mag = b_neg ? -wb : wb;
  wire div_zero = (wb == '0);
  wire ovf = ~req_unsigned & (wa == (req_word ? MIN_WORD : MIN_FULL)) & (wb == '1);
  wire accept = req_valid & req_ready;

  wire [XLEN-1:0] spec_res = div_zero ? (req_rem ? wa : '1) : (req_rem ? '0 : wa);

  wire [XLEN:0] shifted = {rem, quo[XLEN-1]};
  wire [XLEN:0] diff    = shifted - {1'b0, dvs};
  wire          fits    = ~diff[XLEN];

  wire [XLEN-1:0] q_fin = neg_q ? -quo : quo;
  wire [XLEN-1:0] r_fin = neg_r ? -rem : rem;

  assign req_ready = ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      quo       <= '0;
      rem       <= '0;
      dvs       <= '0;
      neg_q     <= 1'b0;
      neg_r     <= 1'b0;
      sel_rem   <= 1'b0;
      wrd       <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        if (div_zero || ovf) begin
          rsp_valid <= 1'b1;
          rsp_data  <= fix(spec_res, req_word);
        end else begin
          busy    <= 1'b1;
          cnt     <= req_word ? CW'(WLEN) : CW'(XLEN);
          quo     <= req_word ? (a_mag << WLEN) : a_mag;
          rem     <= '0;
          dvs     <= b_mag;
          neg_q   <= a_neg ^ b_neg;
          neg_r   <= a_neg;
          sel_rem <= req_rem;
          wrd     <= req_word;
        end
      end else if (busy) begin
        if (cnt != '0) begin
          rem <= fits ? diff[XLEN-1:0] : shifted[XLEN-1:0];
          quo <= {quo[XLEN-2:0], fits};
          cnt <= cnt - 1'b1;
        end else begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_data  <= fix(sel_rem ? r_fin : q_fin, wrd);
        end
      end
    end
  end
endmodule

// File: rtl/rv_divider_chk.sv
module rv_divider_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [XLEN-1:0] req_a,
  input logic [XLEN-1:0] req_b,
  input logic            req_rem,
  input logic            req_unsigned,
  input logic            req_word,
  input logic            rsp_valid,
  input logic [XLEN-1:0] rsp_data
);
  localparam int WLEN = XLEN / 2;

  wire acc = req_valid & req_ready;
  wire bz  = req_word ? (req_b[WLEN-1:0] == '0) : (req_b == '0);
  wire bm1 = req_word ? (req_b[WLEN-1:0] == '1) : (req_b == '1);
  wire amin = req_word ? (req_a[WLEN-1:0] == {1'b1, {(WLEN-1){1'b0}}})
                       : (req_a == {1'b1, {(XLEN-1){1'b0}}});
  wire ov  = ~req_unsigned & amin & bm1;

  logic last_word;
  always_ff @(posedge clk) begin
    if (!rst_n) last_word <= 1'b0;
    else if (acc) last_word <= req_word;
  end

  // R3
  zero_div_quot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && bz && !req_rem |=> rsp_valid && rsp_data == '1);

  // R5
  ovf_rem_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ov && !bz && req_rem |=> rsp_valid && rsp_data == '0);

  // R7
  special_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (bz || ov) |=> rsp_valid && req_ready);

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !bz && !ov |=> !req_ready && !rsp_valid);

  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  // R6
  word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && last_word |-> rsp_data[XLEN-1:WLEN] == {WLEN{rsp_data[WLEN-1]}});
endmodule

bind rv_divider rv_divider_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_a(req_a), .req_b(req_b), .req_rem(req_rem), .req_unsigned(req_unsigned),
  .req_word(req_word), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
);

// File: tb/rv_divider_bench.sv
`timescale 1ns/1ps
module rv_divider_bench;
  localparam int XL = 8;
  localparam int WL = XL / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [XL-1:0] req_a = '0, req_b = '0;
  logic req_rem = 1'b0, req_unsigned = 1'b0, req_word = 1'b0;
  logic rsp_valid;
  logic [XL-1:0] rsp_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rv_divider #(.XLEN(XL)) u_rv_divider (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_a(req_a), .req_b(req_b), .req_rem(req_rem), .req_unsigned(req_unsigned),
    .req_word(req_word), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  function automatic longint as_int(input logic [XL-1:0] v, input logic uns, input logic w);
    int wd = w ? WL : XL;
    longint x = longint'(v) & ((64'sd1 <<< wd) - 1);
    if (!uns && x[wd-1]) x = x - (64'sd1 <<< wd);
    return x;
  endfunction

  function automatic logic [XL-1:0] ref_div(input logic [XL-1:0] a, b,
                                            input logic rm, uns, w);
    int wd = w ? WL : XL;
    longint sa = as_int(a, uns, w);
    longint sb = as_int(b, uns, w);
    longint q, r, res;
    logic [XL-1:0] o;
    if (sb == 0) begin q = -1; r = sa; end
    else if (!uns && sa == -(64'sd1 <<< (wd-1)) && sb == -1) begin q = sa; r = 0; end
    else begin q = sa / sb; r = sa % sb; end
    res = rm ? r : q;
    o = res[XL-1:0];
    if (w) o = {{WL{o[WL-1]}}, o[WL-1:0]};
    return o;
  endfunction

  task automatic run(input logic [XL-1:0] a, b, input logic rm, uns, w);
    logic [XL-1:0] exp = ref_div(a, b, rm, uns, w);
    longint sa = as_int(a, uns, w);
    longint sb = as_int(b, uns, w);
    int wd = w ? WL : XL;
    bit spec = (sb == 0) || (!uns && sa == -(64'sd1 <<< (wd-1)) && sb == -1);
    string tag;
    int edges = 0;
    if (sb == 0) tag = rm ? "R4" : "R3";
    else if (spec) tag = "R5";
    else if (w) tag = "R6";
    else if (uns) tag = "R2";
    else tag = "R1";
    @(negedge clk);
    req_valid = 1'b1; req_a = a; req_b = b;
    req_rem = rm; req_unsigned = uns; req_word = w;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!spec) check("R8 ready low while busy", longint'(req_ready), 0);
    while (!rsp_valid && edges < 100) begin
      @(negedge clk);
      edges++;
    end
    if (spec) check("R7 special latency", edges, 0);
    else check("R8 latency", edges, wd + 1);
    check(tag, longint'(rsp_data), longint'(exp));
    @(negedge clk);
    check("R9 single strobe", longint'(rsp_valid), 0);
  endtask

  initial begin
    #(190000 * 5.0);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [XL-1:0] dv[10] = '{8'h00, 8'h01, 8'hFF, 8'h02, 8'h03, 8'h07,
                              8'h80, 8'hF9, 8'h10, 8'h3C};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset rsp_valid", longint'(rsp_valid), 0);
    check("R8 reset ready", longint'(req_ready), 0 + 1);
    rst_n = 1'b1;
    for (int f = 0; f < 8; f++) begin
      for (int i = 0; i < 64; i++) begin
        for (int d = 0; d < 10; d++) begin
          run(XL'(i * 4), dv[d], f[0], f[1], f[2]);
          run(XL'(255 - i * 4), dv[d], f[0], f[1], f[2]);
        end
      end
    end
    summary();
  end
endmodule